// File: doc/BRIEF.md
# Token-Ring Depth-Cascaded FIFO

This block builds one deep first-in first-out queue from several identical storage cells joined in a ring. Every cell sees the same write strobe, read strobe and write data, and all cells feed one shared read-data bus. No word ever moves from cell to cell. Instead, two ownership tokens travel around the ring. The cell that holds the write token takes the next accepted write. The cell that holds the read token presents the head word and takes the next accepted read. A cell hands a token on through a one-cycle active-low pulse on its expansion link. It sends the pulse while it fills its last location, for the write token, or while it reads its last valid location, for the read token. The next cell in the ring receives the pulse, so each word is stored once and reaches the output with no added delay.

One cell is fixed as the first-load cell by a parameter. After reset it holds both tokens. The shared full and empty flags are active low, and each is the wired combination of the per-cell flags. The cascade cannot use a half-full flag or a read-pointer rewind, so in ring configurations the half-full output stays inactive and the rewind request is ignored. With a single cell the block runs on its own: it keeps both tokens and provides both of those features.

Top module: `ring_fifo_cascade`

## Requirements
- R1: While reset is low and directly after it is released, empty_n is 0, full_n is 1, half_n is 1 and every bit of link_w_n and link_r_n is 1.
- R2: Words leave in the order they were accepted, across all cells. The head word is shown on dout whenever empty_n is 1, and it is removed at the rising clock edge of a cycle in which rd is 1.
- R3: After CELLS*DEPTH accepted writes with no reads, full_n is 0. A write presented while full_n is 0 is not stored.
- R4: When no words are held, empty_n is 0. A read presented then removes nothing, and the next word written becomes the head.
- R5: Each write goes to exactly one cell. A write in the cycle right after a cell fills its last location lands in the next cell, with no lost cycle.
- R6: The write token and the read token move independently. Simultaneous reads and writes keep FIFO order while both tokens cross cell boundaries.
- R7: link_w_n[i] is 0 for exactly the one cycle in which cell i accepts a write into its last location. link_r_n[i] behaves the same way for a read of its last location. Cell 0 is the first-load cell.
- R8: With more than one cell, half_n stays 1 and a pulse on retx, given while wr and rd are 0, leaves the contents and the read order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr | input | 1 | Shared write strobe |
| din | input | WIDTH | Shared write data |
| rd | input | 1 | Shared read strobe |
| retx | input | 1 | Read-pointer rewind request (single-cell mode only) |
| dout | output | WIDTH | Head word from the cell holding the read token |
| full_n | output | 1 | Composite full flag, active low |
| empty_n | output | 1 | Composite empty flag, active low |
| half_n | output | 1 | Half-full flag, active low (single-cell mode only) |
| link_w_n | output | CELLS | Write-token expansion pulses, one per cell |
| link_r_n | output | CELLS | Read-token expansion pulses, one per cell |

## Verification
The first pattern fills the whole ring with writes alone and then drains it with reads alone. This separates the write token's trip through every cell from the read token's trip, and it shows at which cycle each expansion pulse appears. Writes against a full ring, reads against an empty ring and a rewind request while the ring is partly filled each show whether a stray strobe or request can change what comes out. Steady simultaneous reading and writing, started with a small lead of stored words, moves both tokens across cell boundaries at different moments. This exposes any coupling between the two tokens and any lost cycle at a hand-over.

// File: rtl/ring_fifo_pkg.sv
package ring_fifo_pkg;

   // One expansion link: separate active-low pulses for each token kind.
   typedef struct packed {
      logic w_n;
      logic r_n;
   } xlink_t;

   localparam xlink_t XLINK_IDLE = '{w_n: 1'b1, r_n: 1'b1};

endpackage

// File: rtl/ring_fifo_cell.sv
module ring_fifo_cell
   import ring_fifo_pkg::*;
#(
   parameter int WIDTH = 9,
   parameter int DEPTH = 4,
   parameter bit SOLO  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fl_n,
   input  xlink_t           xi,
   input  logic             wr,
   input  logic             rd,
   input  logic             retx,
   input  logic [WIDTH-1:0] din,
   output xlink_t           xo,
   output logic [WIDTH-1:0] dout,
   output logic             drive,
   output logic             full_n,
   output logic             empty_n,
   output logic             half_n,
   output logic             wtok_o,
   output logic             rtok_o
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   initial begin
      if (DEPTH < 2 || (1 << PW) != DEPTH)
         $error("ring_fifo_cell: DEPTH must be a power of two, at least 2");
      if (WIDTH < 1)
         $error("ring_fifo_cell: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             wtok, rtok;
   logic             wacc, racc, wpass, rpass, rewind;

   assign wacc   = rst_n & wr & wtok & (cnt != CW'(DEPTH));
   assign racc   = rst_n & rd & rtok & (cnt != '0);
   assign wpass  = !SOLO & wacc & (wptr == LAST);
   assign rpass  = !SOLO & racc & (rptr == LAST);
   assign rewind = SOLO & retx & !wr & !rd;

   assign xo.w_n = ~wpass;
   assign xo.r_n = ~rpass;

   always_ff @(posedge clk) begin
      if (wacc) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
         wtok <= SOLO | ~fl_n;
         rtok <= SOLO | ~fl_n;
      end else begin
         if (wacc) wptr <= wptr + 1'b1;
         if (rewind) begin
            rptr <= '0;
            cnt  <= CW'(wptr);
         end else begin
            if (racc) rptr <= rptr + 1'b1;
            cnt <= cnt + CW'(wacc) - CW'(racc);
         end
         if (!SOLO) begin
            if (wpass)          wtok <= 1'b0;
            else if (!xi.w_n)   wtok <= 1'b1;
            if (rpass)          rtok <= 1'b0;
            else if (!xi.r_n)   rtok <= 1'b1;
         end
      end
   end

   assign dout    = mem[rptr];
   assign drive   = rtok & (cnt != '0);
   assign full_n  = (cnt != CW'(DEPTH));
   assign empty_n = (cnt != '0);
   assign wtok_o  = wtok;
   assign rtok_o  = rtok;

   generate
      if (SOLO) begin : g_half
         assign half_n = !(cnt > CW'(DEPTH / 2));
      end else begin : g_nohalf
         assign half_n = 1'b1;
      end
   endgenerate

   // R7: a hand-over pulse never lasts a second cycle
   a_r7_wpulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !xo.w_n |=> xo.w_n);
   a_r7_rpulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !xo.r_n |=> xo.r_n);
   // R5: the sender gives its token up after the pulse
   a_r5_pass_drops_wtok: assert property (@(posedge clk) disable iff (!rst_n)
      !xo.w_n |=> !wtok);
   // R3: the cell never holds more than its depth
   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   // R1: links stay idle while reset is held
   always_comb begin
      if (rst_n === 1'b0)
         a_r1_reset_links_idle: assert (xo.w_n && xo.r_n);
   end

endmodule

// File: rtl/ring_fifo_cascade.sv
module ring_fifo_cascade
   import ring_fifo_pkg::*;
#(
   parameter int WIDTH  = 9,
   parameter int DEPTH  = 4,
   parameter int CELLS  = 3,
   parameter int MASTER = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] din,
   input  logic             rd,
   input  logic             retx,
   output logic [WIDTH-1:0] dout,
   output logic             full_n,
   output logic             empty_n,
   output logic             half_n,
   output logic [CELLS-1:0] link_w_n,
   output logic [CELLS-1:0] link_r_n
);

   localparam bit SOLO = (CELLS == 1);

   initial begin
      if (CELLS < 1 || MASTER < 0 || MASTER >= CELLS)
         $error("ring_fifo_cascade: need CELLS >= 1 and MASTER inside the ring");
   end

   xlink_t             xo [CELLS];
   logic [WIDTH-1:0]   cdat [CELLS];
   logic [CELLS-1:0]   drive_v, full_v, empty_v, half_v, wtok_v, rtok_v;

   generate
      for (genvar i = 0; i < CELLS; i++) begin : g_cell
         localparam int PREV = (i + CELLS - 1) % CELLS;
         ring_fifo_cell #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SOLO(SOLO)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .fl_n    (i != MASTER),
            .xi      (SOLO ? XLINK_IDLE : xo[PREV]),
            .wr      (wr),
            .rd      (rd),
            .retx    (retx),
            .din     (din),
            .xo      (xo[i]),
            .dout    (cdat[i]),
            .drive   (drive_v[i]),
            .full_n  (full_v[i]),
            .empty_n (empty_v[i]),
            .half_n  (half_v[i]),
            .wtok_o  (wtok_v[i]),
            .rtok_o  (rtok_v[i])
         );
         assign link_w_n[i] = xo[i].w_n;
         assign link_r_n[i] = xo[i].r_n;
      end
   endgenerate

   always_comb begin
      dout = '0;
      for (int i = 0; i < CELLS; i++)
         if (drive_v[i]) dout = dout | cdat[i];
   end

   // Active-low flags: asserted only when every cell asserts.
   assign full_n  = |full_v;
   assign empty_n = |empty_v;

   generate
      if (SOLO) begin : g_solo_half
         assign half_n = half_v[0];
      end else begin : g_ring_half
         assign half_n = 1'b1;
      end
   endgenerate

   // R5: exactly one cell owns each token at any time
   a_r5_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(wtok_v));
   a_r6_one_reader: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(rtok_v));
   // R5: at most one cell drives the shared read bus
   a_r5_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drive_v));
   // R4: a non-empty ring always has a cell presenting the head
   a_r4_head_present: assert property (@(posedge clk) disable iff (!rst_n)
      empty_n |-> (drive_v != '0));

endmodule

// File: tb/ring_fifo_cascade_test.sv
module ring_fifo_cascade_test;

   localparam int WIDTH = 9;
   localparam int DEPTH = 4;
   localparam int CELLS = 3;
   localparam int CAP   = DEPTH * CELLS;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr = 1'b0, rd = 1'b0, retx = 1'b0;
   logic [WIDTH-1:0] din = '0;
   logic [WIDTH-1:0] dout;
   logic             full_n, empty_n, half_n;
   logic [CELLS-1:0] link_w_n, link_r_n;

   int errors = 0;
   int checks = 0;
   logic [WIDTH-1:0] q[$];

   always #4 clk = ~clk;

   ring_fifo_cascade #(.WIDTH(WIDTH), .DEPTH(DEPTH), .CELLS(CELLS), .MASTER(0)) uut (
      .clk(clk), .rst_n(rst_n), .wr(wr), .din(din), .rd(rd), .retx(retx),
      .dout(dout), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
      .link_w_n(link_w_n), .link_r_n(link_r_n)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One clock cycle: drive at the falling edge, check before the rising edge.
   task automatic step(input logic w, input logic r, input logic [WIDTH-1:0] d,
                       input string tag);
      bit wa, ra;
      @(negedge clk);
      wr = w; rd = r; din = d; retx = 1'b0;
      #1;
      check(full_n == (q.size() != CAP), "R3 full flag", full_n, q.size() != CAP);
      check(empty_n == (q.size() != 0), "R4 empty flag", empty_n, q.size() != 0);
      if (q.size() != 0)
         check(dout == q[0], tag, dout, q[0]);
      wa = w && (q.size() < CAP);
      ra = r && (q.size() > 0);
      @(posedge clk);
      if (ra) void'(q.pop_front());
      if (wa) q.push_back(d);
   endtask

   task automatic t_reset;
      check(empty_n == 1'b0, "R1 empty in reset", empty_n, 0);
      check(full_n == 1'b1, "R1 full in reset", full_n, 1);
      check(half_n == 1'b1, "R1 half in reset", half_n, 1);
      check(link_w_n == '1 && link_r_n == '1, "R1 links in reset",
            {link_w_n, link_r_n}, '1);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check(empty_n == 1'b0 && full_n == 1'b1, "R1 flags after reset",
            {empty_n, full_n}, 2'b01);
   endtask

   task automatic t_fill_drain;
      for (int i = 0; i < CAP; i++) begin
         @(negedge clk);
         wr = 1'b1; din = WIDTH'(9'h40 + i * 7); rd = 1'b0;
         #1;
         if (i == DEPTH - 1)
            check(link_w_n[0] == 1'b0, "R7 cell0 write pulse", link_w_n[0], 0);
         if (i == DEPTH)
            check(link_w_n == '1, "R7 pulse ends after one cycle", link_w_n, '1);
         if (i == 2 * DEPTH - 1)
            check(link_w_n[1] == 1'b0, "R5 cell1 write pulse", link_w_n[1], 0);
         check(full_n == 1'b1, "R3 not full while filling", full_n, 1);
         @(posedge clk);
         q.push_back(din);
      end
      step(1'b1, 1'b0, 9'h1FF, "R3 head while full");   // ignored write
      check(full_n == 1'b0, "R3 full after capacity", full_n, 0);
      check(half_n == 1'b1, "R8 half stays inactive", half_n, 1);
      @(negedge clk); wr = 1'b0; retx = 1'b1;
      @(negedge clk); retx = 1'b0;
      for (int i = 0; i < CAP; i++) begin
         step(1'b0, 1'b1, '0, (i == 0) ? "R8 order after retx" : "R2 drain order");
         if (i == DEPTH - 1)
            check(link_r_n[0] == 1'b0, "R7 cell0 read pulse", link_r_n[0], 0);
      end
      step(1'b0, 1'b0, '0, "R2 idle");
      check(empty_n == 1'b0, "R4 empty after drain", empty_n, 0);
      step(1'b0, 1'b1, '0, "R4 read while empty");
      step(1'b1, 1'b0, 9'h0A5, "R4 write after empty read");
      step(1'b0, 1'b0, '0, "R4 new head");
      check(dout == 9'h0A5, "R4 head after empty read", dout, 9'h0A5);
      step(1'b0, 1'b1, '0, "R4 pop");
      step(1'b0, 1'b0, '0, "R4 idle");
   endtask

   task automatic t_stream;
      step(1'b1, 1'b0, 9'h101, "R6 prime");
      step(1'b1, 1'b0, 9'h102, "R6 prime");
      for (int i = 0; i < 3 * CAP; i++)
         step(1'b1, 1'b1, WIDTH'(9'h110 + i * 3), "R6 stream order");
      for (int i = 0; i < 2; i++)
         step(1'b0, 1'b1, '0, "R6 tail order");
      step(1'b0, 1'b0, '0, "R6 idle");
      check(empty_n == 1'b0, "R6 empty after stream", empty_n, 0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      t_fill_drain();
      t_stream();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule